// File: doc/BRIEF.md
# Vectored Interrupt Cycle Controller

This block decides what happens in the interrupt-check pass that a simple processor performs after every executed instruction. While `chk_en` is high it looks at six pending causes: arithmetic overflow, memory-protection violation, privileged-opcode violation, timer expiry, I/O completion and supervisor call. It picks the single most urgent one and returns the next program counter, stack pointer and mode that the surrounding sequencer should load. Whether or not a cause was taken, the sequencer returns to instruction fetch afterwards.

The three synchronous traps (overflow, protection, privilege) abandon the running program. They jump to their handler and enter supervisor mode without saving any state. Timer, I/O and supervisor call are resumable. For these the block asks for a stack write of the current PC at the current SP, advances SP by one, and only then jumps to the handler. Handler entry addresses come from six internal vector registers. The timer expiry cause is produced inside the block by a down-counter that runs only in user mode. The vector registers and the timer reload value share one write port.

All results of the check are combinational and valid in the cycle in which `chk_en` is high. The only state is the vector table, the timer count and the timer-pending flag.

Top module: `irq_vector_ctl`

## Requirements
- R1: At most one cause is taken per check. The highest-priority pending cause wins, in the order overflow (index 0), protection (1), privilege (2), timer (3), I/O (4), supervisor call (5). `evt_cause` reports that index and `flag_clr` has exactly that bit set.
- R2: A write with `cfg_addr` 0 to 5 stores `cfg_data` as the handler address of the cause with that index. A taken cause drives `pc_next` to its stored address, and a later write takes effect for later checks.
- R3: A trap cause (index 0, 1 or 2) raises no stack write and leaves `sp_next` equal to `sp_in`.
- R4: A resumable cause (index 3, 4 or 5) raises `stk_we` with `stk_addr` = `sp_in` and `stk_data` = `pc_in`, and drives `sp_next` = `sp_in` + 1.
- R5: A taken cause drives `mode_next` to 1 (supervisor). When no cause is taken, or `chk_en` is low, `evt_taken`, `stk_we` and `flag_clr` are 0 and `pc_next`, `sp_next`, `mode_next` equal their inputs. Mode 0 means user.
- R6: A write with `cfg_addr` 6 loads the timer with `cfg_data[TW-1:0]`. After that edge the timer drops by one on each clock edge with `mode_in` = 0. `ti_flag` rises at the edge where the count reaches zero, so it rises N edges after a reload of N.
- R7: The timer holds its count on edges with `mode_in` = 1. Once it reaches zero it stays there, and does not raise `ti_flag` again, until it is reloaded.
- R8: `ti_flag` clears at the edge of a check that takes the timer cause. It stays set when a higher cause is taken instead. A lower external cause that was not taken is not cleared and is taken on a later check.
- R9: After reset the vectors and the timer are 0, `ti_flag` is 0 and no cause is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_en | input | 1 | Interrupt-check pass is active this cycle |
| ov_flag | input | 1 | Overflow pending |
| mp_flag | input | 1 | Memory-protection violation pending |
| pi_flag | input | 1 | Privileged-opcode violation pending |
| io_flag | input | 1 | I/O completion pending |
| svc_flag | input | 1 | Supervisor call pending |
| pc_in | input | AW | Current program counter |
| sp_in | input | AW | Current stack pointer |
| mode_in | input | 1 | Current mode, 1 = supervisor |
| cfg_we | input | 1 | Write strobe for vector or timer reload |
| cfg_addr | input | 3 | 0 to 5 vector index, 6 timer reload |
| cfg_data | input | AW | Write data |
| pc_next | output | AW | PC to load after the check |
| sp_next | output | AW | SP to load after the check |
| mode_next | output | 1 | Mode to load after the check |
| evt_taken | output | 1 | A cause was taken |
| evt_cause | output | 3 | Index of the taken cause |
| stk_we | output | 1 | Stack write request |
| stk_addr | output | AW | Stack write address |
| stk_data | output | AW | Stack write data (return PC) |
| flag_clr | output | 6 | One-hot clear of the taken cause |
| ti_flag | output | 1 | Timer cause pending |

## Verification
The assertions assume that the external cause flags are steady while `chk_en` is high. They also assume that the sequencer applies `flag_clr` before the next check and that `mode_in` is a clean 0 or 1 on every edge, because the timer hold rule is judged edge by edge. The stimulus changes inputs only at falling edges. It holds each check for exactly one cycle and drops all external flags afterwards. It keeps the timer at zero during the priority tests, so the internal timer cause shows up only in the passes that are meant to contain it.

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl #(
  parameter int AW = 16,
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chk_en,
  input  logic          ov_flag,
  input  logic          mp_flag,
  input  logic          pi_flag,
  input  logic          io_flag,
  input  logic          svc_flag,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] sp_in,
  input  logic          mode_in,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [AW-1:0] cfg_data,
  output logic [AW-1:0] pc_next,
  output logic [AW-1:0] sp_next,
  output logic          mode_next,
  output logic          evt_taken,
  output logic [2:0]    evt_cause,
  output logic          stk_we,
  output logic [AW-1:0] stk_addr,
  output logic [AW-1:0] stk_data,
  output logic [5:0]    flag_clr,
  output logic          ti_flag
);
  localparam int NCAUSE = 6;
  localparam logic [2:0] RELOAD_SEL = 3'd6;
  localparam logic [2:0] TIMER_IDX = 3'd3;

  logic [AW-1:0] vec [NCAUSE];
  logic [TW-1:0] tmr;
  logic          ti_pend;
  logic [5:0]    pend;
  logic          resumable;
  logic          reload;

  assign pend   = {svc_flag, io_flag, ti_pend, pi_flag, mp_flag, ov_flag};
  assign reload = cfg_we && (cfg_addr == RELOAD_SEL);

  always_comb begin
    evt_cause = 3'd0;
    for (int i = NCAUSE - 1; i >= 0; i--)
      if (pend[i]) evt_cause = 3'(i);
  end

  assign evt_taken = chk_en && (pend != 6'd0);
  assign resumable = evt_cause >= TIMER_IDX;
  assign stk_we    = evt_taken && resumable;
  assign stk_addr  = sp_in;
  assign stk_data  = pc_in;
  assign pc_next   = evt_taken ? vec[evt_cause] : pc_in;
  assign sp_next   = stk_we ? sp_in + AW'(1) : sp_in;
  assign mode_next = evt_taken ? 1'b1 : mode_in;
  assign flag_clr  = evt_taken ? (6'd1 << evt_cause) : 6'd0;
  assign ti_flag   = ti_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NCAUSE; k++) vec[k] <= '0;
    end else if (cfg_we && cfg_addr < 3'(NCAUSE)) begin
      vec[cfg_addr] <= cfg_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr     <= '0;
      ti_pend <= 1'b0;
    end else begin
      if (reload)
        tmr <= cfg_data[TW-1:0];
      else if (!mode_in && tmr != '0)
        tmr <= tmr - TW'(1);
      if (!reload && !mode_in && tmr == TW'(1))
        ti_pend <= 1'b1;
      else if (flag_clr[TIMER_IDX])
        ti_pend <= 1'b0;
    end
  end

  AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flag_clr)); // R1
  AST_CLEAR_TRACKS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    evt_taken |-> $countones(flag_clr) == 1); // R1
  AST_TRAP_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && (ov_flag || mp_flag || pi_flag)) |-> (!stk_we && sp_next == sp_in)); // R3
  AST_PUSH_ADVANCES_SP: assert property (@(posedge clk) disable iff (!rst_n)
    stk_we |-> (sp_next == stk_addr + AW'(1) && stk_data == pc_in)); // R4
  AST_SUPERVISOR_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_taken |-> mode_next); // R5
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en |-> (!stk_we && flag_clr == 6'd0 && pc_next == pc_in)); // R5
  AST_TI_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ti_pend) |-> (tmr == '0 && $past(tmr) == TW'(1))); // R6
  AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in && !reload) |=> $stable(tmr)); // R7
  AST_TI_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr[TIMER_IDX] && !(!reload && !mode_in && tmr == TW'(1))) |=> !ti_pend); // R8
endmodule

// File: tb/sim_irq_vector_ctl.sv
module sim_irq_vector_ctl;
  localparam int AW = 16;
  localparam int TW = 12;

  logic clk = 0, rst_n = 0;
  logic chk_en = 0, ov = 0, mp = 0, pi = 0, io = 0, svc = 0, mode_in = 0;
  logic [AW-1:0] pc_in = '0, sp_in = '0, cfg_data = '0;
  logic cfg_we = 0;
  logic [2:0] cfg_addr = '0;
  logic [AW-1:0] pc_next, sp_next, stk_addr, stk_data;
  logic mode_next, evt_taken, stk_we, ti_flag;
  logic [2:0] evt_cause;
  logic [5:0] flag_clr;

  typedef struct packed {
    logic [AW-1:0] pc;
    logic [AW-1:0] sp;
    logic          mode;
    logic          taken;
    logic [2:0]    cause;
    logic          we;
    logic [AW-1:0] saddr;
    logic [AW-1:0] sdata;
    logic [5:0]    clr;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  logic [AW-1:0] vmodel [6];
  logic ti_model = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_vector_ctl #(.AW(AW), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en),
    .ov_flag(ov), .mp_flag(mp), .pi_flag(pi), .io_flag(io), .svc_flag(svc),
    .pc_in(pc_in), .sp_in(sp_in), .mode_in(mode_in),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .pc_next(pc_next), .sp_next(sp_next), .mode_next(mode_next),
    .evt_taken(evt_taken), .evt_cause(evt_cause), .stk_we(stk_we),
    .stk_addr(stk_addr), .stk_data(stk_data), .flag_clr(flag_clr), .ti_flag(ti_flag));

  task automatic chk_bit(input string tag, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, expv);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_data = d;
    if (a < 3'd6) vmodel[a] = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic drive(input string tag, input logic en, input logic [5:0] f,
                       input logic [AW-1:0] pc, input logic [AW-1:0] sp, input logic md);
    exp_t e;
    logic [5:0] p;
    @(negedge clk);
    chk_en = en; ov = f[0]; mp = f[1]; pi = f[2]; io = f[4]; svc = f[5];
    pc_in = pc; sp_in = sp; mode_in = md;
    p = {f[5], f[4], ti_model, f[2], f[1], f[0]};
    e = '0;
    e.pc = pc; e.sp = sp; e.mode = md; e.saddr = sp; e.sdata = pc;
    if (en && p != 6'd0) begin
      for (int i = 5; i >= 0; i--) if (p[i]) e.cause = 3'(i);
      e.taken = 1; e.mode = 1; e.pc = vmodel[e.cause];
      e.clr = 6'd1 << e.cause;
      if (e.cause >= 3'd3) begin e.we = 1; e.sp = sp + 1; end
      if (e.cause == 3'd3) ti_model = 0;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    chk_en = 0; ov = 0; mp = 0; pi = 0; io = 0; svc = 0;
  endtask

  initial begin : monitor
    exp_t e, a;
    string t;
    forever begin
      @(negedge clk);
      #2;
      while (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a.pc = pc_next; a.sp = sp_next; a.mode = mode_next; a.taken = evt_taken;
        a.cause = evt_taken ? evt_cause : 3'd0; a.we = stk_we;
        a.saddr = e.we ? stk_addr : e.saddr; a.sdata = e.we ? stk_data : e.sdata;
        a.clr = flag_clr;
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s actual pc=%h sp=%h md=%b tk=%b c=%0d we=%b clr=%b expected pc=%h sp=%h md=%b tk=%b c=%0d we=%b clr=%b",
                   t, a.pc, a.sp, a.mode, a.taken, a.cause, a.we, a.clr,
                   e.pc, e.sp, e.mode, e.taken, e.cause, e.we, e.clr);
        end
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : main
    for (int i = 0; i < 6; i++) vmodel[i] = '0;
    idle(3);
    rst_n = 1;
    @(negedge clk); #1;
    chk_bit("R9 ti after reset", ti_flag, 1'b0);
    drive("R9 R5 quiet check", 1, 6'b000000, 16'h0420, 16'h0800, 0);
    drive("R2 zero vector after reset", 1, 6'b000001, 16'h0421, 16'h0800, 0);
    for (int i = 0; i < 6; i++) cfg_write(3'(i), 16'h1000 + 16'(i) * 16'h0111);
    drive("R2 R3 overflow trap", 1, 6'b000001, 16'h0430, 16'h0800, 0);
    drive("R1 all external pending", 1, 6'b110111, 16'h0431, 16'h0800, 0);
    drive("R1 protection wins", 1, 6'b010110, 16'h0432, 16'h0801, 0);
    drive("R3 privilege over svc", 1, 6'b100100, 16'h0433, 16'h0802, 0);
    drive("R4 io push", 1, 6'b010000, 16'h0434, 16'h0803, 0);
    drive("R4 svc push", 1, 6'b100000, 16'h0435, 16'hFFFF, 0);
    drive("R8 io over svc", 1, 6'b110000, 16'h0436, 16'h0810, 0);
    drive("R8 svc later", 1, 6'b100000, 16'h0437, 16'h0811, 0);
    drive("R5 no check enabled", 0, 6'b110111, 16'h0438, 16'h0812, 1);
    drive("R5 supervisor idle", 1, 6'b000000, 16'h0439, 16'h0813, 1);
    mode_in = 0;
    cfg_write(3'd6, 16'd5);
    idle(4); #1;
    chk_bit("R6 ti before zero", ti_flag, 1'b0);
    idle(1); #1;
    chk_bit("R6 ti at zero", ti_flag, 1'b1);
    ti_model = 1;
    drive("R1 R8 overflow over timer", 1, 6'b000001, 16'h0500, 16'h0900, 0);
    #1;
    chk_bit("R8 ti kept", ti_flag, 1'b1);
    drive("R4 R8 timer over io", 1, 6'b010000, 16'h0501, 16'h0901, 0);
    #1;
    chk_bit("R8 ti cleared", ti_flag, 1'b0);
    mode_in = 0;
    idle(10); #1;
    chk_bit("R7 stays at zero", ti_flag, 1'b0);
    cfg_write(3'd6, 16'd4);
    mode_in = 1;
    idle(6);
    mode_in = 0;
    idle(3); #1;
    chk_bit("R7 held in supervisor", ti_flag, 1'b0);
    idle(1); #1;
    chk_bit("R6 R7 expiry after hold", ti_flag, 1'b1);
    ti_model = 1;
    drive("R4 timer alone", 1, 6'b000000, 16'h0600, 16'h0A00, 0);
    cfg_write(3'd2, 16'h7ABC);
    drive("R2 rewritten vector", 1, 6'b000100, 16'h0601, 16'h0A01, 1);
    idle(3);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : watchdog
    #200000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule